// File: doc/BRIEF.md
# Dual-Lane SHA-512 Message Schedule Sigma1 Accumulator

This unit carries out the second schedule-update step of SHA-512 on two independent 64-bit words packed into one 128-bit operation. An instruction word comes in with three 128-bit operands: the old value of the destination register and two source registers. The unit checks that the word carries the schedule-update encoding and extracts the three register indices so that a register file can be read and written. For each 64-bit lane it forms the small sigma1 of the first source's lane. It then adds that value, together with the second source's lane, to the destination's old lane.

A feature-enable input gates the operation. A matching word with the feature off is flagged undefined and produces no result. A word that does not match raises a mismatch flag. With the default output register, each accepted word yields `out_valid` and the 128-bit result one cycle later. The result and its destination index are held until the next accepted word. Setting `OUT_REG` to 0 gives a purely combinational variant.

Top module: `sha512_sched_upd2`

## Requirements
- R1: A word is accepted only when its bits 31:21 equal 11001110011 and its bits 15:10 equal 100010; with in_valid and feature_en high it produces out_valid one cycle later.
- R2: The index outputs follow the instruction word combinationally: idx_m from bits 20:16, idx_n from bits 9:5 and idx_d from bits 4:0; out_dst carries the idx_d of the accepted word together with its result.
- R3: Result bits 63:0 equal old_d[63:0] + sig1(src_n[63:0]) + src_m[63:0] mod 2^64, where sig1(v) = ror(v,19) ^ ror(v,61) ^ (v >> 6), with zeros shifted in at the top.
- R4: Result bits 127:64 equal old_d[127:64] + sig1(src_n[127:64]) + src_m[127:64] mod 2^64.
- R5: No carry passes from the lower lane into the upper lane.
- R6: A matching word presented with in_valid while feature_en is low raises out_undef one cycle later, does not raise out_valid, and leaves out_result unchanged.
- R7: A non-matching word presented with in_valid raises out_mismatch one cycle later, does not raise out_valid, and leaves out_result unchanged.
- R8: With OUT_REG=1 the latency from an accepted word to out_valid is exactly one cycle; out_valid, out_undef and out_mismatch are pulses that are low in any cycle that follows a cycle without in_valid.
- R9: Synchronous active-high reset clears out_valid, out_undef, out_mismatch, out_result and out_dst to zero.
- R10: out_result and out_dst hold their values across cycles in which no word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feature_en | input | 1 | SHA-512 feature enable |
| in_valid | input | 1 | Instruction and operands are presented |
| insn | input | 32 | Instruction word |
| old_d | input | 128 | Old destination register value |
| src_n | input | 128 | Source operand fed through sigma1 |
| src_m | input | 128 | Source operand added directly |
| idx_d | output | 5 | Destination register index |
| idx_n | output | 5 | Sigma source register index |
| idx_m | output | 5 | Addend source register index |
| out_valid | output | 1 | Result is valid |
| out_undef | output | 1 | Matching word issued with the feature disabled |
| out_mismatch | output | 1 | Word does not carry this encoding |
| out_result | output | 128 | Two-lane result |
| out_dst | output | 5 | Destination index of the result |

## Verification
The same cycle can present the result of one accepted word and take in the next word, which may be accepted, flagged undefined or flagged a mismatch. The bench issues words back to back with no idle gap, so each output check falls in the cycle in which the following word is already driven. A flagged word that follows an accepted one must leave the previous result in place, and this is judged against the bench model's value for the earlier word. Random operand streams are mixed with all-ones, single-bit and carry-boundary vectors.

// File: rtl/sha512_sched_upd2.sv
module sha512_sched_upd2 #(
  parameter bit OUT_REG = 1'b1,
  localparam int LW = 64,
  localparam int NL = 2,
  localparam int VW = LW * NL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          feature_en,
  input  logic          in_valid,
  input  logic [31:0]   insn,
  input  logic [VW-1:0] old_d,
  input  logic [VW-1:0] src_n,
  input  logic [VW-1:0] src_m,
  output logic [4:0]    idx_d,
  output logic [4:0]    idx_n,
  output logic [4:0]    idx_m,
  output logic          out_valid,
  output logic          out_undef,
  output logic          out_mismatch,
  output logic [VW-1:0] out_result,
  output logic [4:0]    out_dst
);

  localparam logic [10:0] HI_OPC = 11'b11001110011;
  localparam logic [5:0]  LO_OPC = 6'b100010;

  function automatic logic [LW-1:0] ssig1(input logic [LW-1:0] v);
    return {v[18:0], v[LW-1:19]} ^ {v[60:0], v[LW-1:61]} ^ {6'b0, v[LW-1:6]};
  endfunction

  logic          hit, go, undef_c, mis_c;
  logic [VW-1:0] sum_c;

  assign idx_m   = insn[20:16];
  assign idx_n   = insn[9:5];
  assign idx_d   = insn[4:0];
  assign hit     = (insn[31:21] == HI_OPC) && (insn[15:10] == LO_OPC);
  assign go      = in_valid && hit && feature_en;
  assign undef_c = in_valid && hit && !feature_en;
  assign mis_c   = in_valid && !hit;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign sum_c[l*LW +: LW] = old_d[l*LW +: LW] + ssig1(src_n[l*LW +: LW]) + src_m[l*LW +: LW];
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid    <= 1'b0;
        out_undef    <= 1'b0;
        out_mismatch <= 1'b0;
        out_result   <= '0;
        out_dst      <= '0;
      end else begin
        out_valid    <= go;
        out_undef    <= undef_c;
        out_mismatch <= mis_c;
        if (go) begin
          out_result <= sum_c;
          out_dst    <= idx_d;
        end
      end
    end

    assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && feature_en && insn[31:21] == HI_OPC && insn[15:10] == LO_OPC) |=> out_valid);

    assert_undef_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !feature_en && insn[31:21] == HI_OPC && insn[15:10] == LO_OPC)
        |=> (out_undef && !out_valid && $stable(out_result)));

    assert_mismatch_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (insn[31:21] != HI_OPC || insn[15:10] != LO_OPC))
        |=> (out_mismatch && !out_valid && $stable(out_result)));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !(out_valid || out_undef || out_mismatch));

    assert_flags_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0({out_valid, out_undef, out_mismatch}));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(out_result) && $stable(out_dst)));
  end else begin : g_comb
    assign out_valid    = go;
    assign out_undef    = undef_c;
    assign out_mismatch = mis_c;
    assign out_result   = sum_c;
    assign out_dst      = idx_d;
  end

endmodule

// File: tb/sim_sha512_sched_upd2.sv
module sim_sha512_sched_upd2;
  logic         clk = 1'b0, rst = 1'b1, feature_en = 1'b1, in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] old_d = '0, src_n = '0, src_m = '0;
  logic [4:0]   idx_d, idx_n, idx_m, out_dst;
  logic         out_valid, out_undef, out_mismatch;
  logic [127:0] out_result;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [127:0] last_res = '0;
  logic [4:0]   last_dst = '0;

  always #5 clk = ~clk;

  sha512_sched_upd2 u0 (.*);

  function automatic logic [63:0] m_sig1(input logic [63:0] v);
    return ((v >> 19) | (v << 45)) ^ ((v >> 61) | (v << 3)) ^ (v >> 6);
  endfunction

  function automatic logic [127:0] m_res(input logic [127:0] d, n, m);
    logic [63:0] hi, lo;
    hi = d[127:64] + m_sig1(n[127:64]) + m[127:64];
    lo = d[63:0] + m_sig1(n[63:0]) + m[63:0];
    return {hi, lo};
  endfunction

  function automatic logic [31:0] enc(input logic [4:0] rm, rn, rd);
    return {11'b11001110011, rm, 6'b100010, rn, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check one full cycle later at the next falling edge
  task automatic issue(input logic [31:0] w, input logic [127:0] d, n, m,
                       input bit fe, input int kind, input string req);
    insn = w; old_d = d; src_n = n; src_m = m; feature_en = fe; in_valid = 1'b1;
    #1;
    chk(idx_m == w[20:16] && idx_n == w[9:5] && idx_d == w[4:0], "R2 idx",
        {113'b0, idx_m, idx_n, idx_d}, {113'b0, w[20:16], w[9:5], w[4:0]});
    @(negedge clk);
    if (kind == 0) begin
      last_res = m_res(d, n, m);
      last_dst = w[4:0];
      chk(out_valid && !out_undef && !out_mismatch, {req, " valid"},
          {125'b0, out_valid, out_undef, out_mismatch}, 128'd4);
    end else if (kind == 1) begin
      chk(!out_valid && out_undef && !out_mismatch, "R6 undef flag",
          {125'b0, out_valid, out_undef, out_mismatch}, 128'd2);
    end else begin
      chk(!out_valid && !out_undef && out_mismatch, "R7 mismatch flag",
          {125'b0, out_valid, out_undef, out_mismatch}, 128'd1);
    end
    chk(out_result == last_res, {req, " result"}, out_result, last_res);
    chk(out_dst == last_dst, {req, " dst"}, {123'b0, out_dst}, {123'b0, last_dst});
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!out_valid && !out_undef && !out_mismatch, "R8 quiet",
          {125'b0, out_valid, out_undef, out_mismatch}, 128'd0);
      chk(out_result == last_res && out_dst == last_dst, "R10 hold", out_result, last_res);
    end
  endtask

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'h5eed_0512));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_undef == 0 && out_mismatch == 0 && out_result == 0 && out_dst == 0,
        "R9 reset", out_result, 128'd0);
    rst = 1'b0;
    @(negedge clk);

    issue(enc(5'd1, 5'd2, 5'd3), '1, '1, '1, 1'b1, 0, "R3 R4 all-ones");
    issue(enc(5'd31, 5'd0, 5'd17), '0, {64'h1, 64'h1}, '0, 1'b1, 0, "R3 R4 single-bit");
    issue(enc(5'd4, 5'd5, 5'd6), '0, {64'h8000_0000_0000_0000, 64'h0000_0000_0008_0000}, '0, 1'b1, 0, "R3 R4 rotate edge");
    issue(enc(5'd7, 5'd8, 5'd9), {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, '0, {64'h0, 64'h1}, 1'b1, 0, "R5 lane carry");
    chk(out_result[127:64] == 64'h0, "R5 upper isolated", out_result, 128'h0);
    issue(enc(5'd10, 5'd11, 5'd12), r128(), r128(), r128(), 1'b0, 1, "R6");
    issue(enc(5'd10, 5'd11, 5'd12) ^ 32'h0000_1000, r128(), r128(), r128(), 1'b1, 2, "R7");
    issue(enc(5'd10, 5'd11, 5'd12) ^ 32'h0200_0000, r128(), r128(), r128(), 1'b1, 2, "R7");
    issue(enc(5'd13, 5'd14, 5'd15), r128(), r128(), r128(), 1'b1, 0, "R1 after flags");
    idle(2);

    for (int i = 0; i < 60; i++) begin
      int k;
      logic [31:0] w;
      k = ($urandom % 8 == 0) ? (1 + $urandom % 2) : 0;
      w = enc(5'($urandom), 5'($urandom), 5'($urandom));
      if (k == 2) w = w ^ (32'h1 << (10 + $urandom % 6));
      issue(w, r128(), r128(), r128(), k != 1, k, "R1 R3 R4 random");
      if ($urandom % 5 == 0) idle(1);
    end
    idle(1);

    rst = 1'b1;
    @(negedge clk);
    chk(out_result == 0 && out_dst == 0 && !out_valid, "R9 re-reset", out_result, 128'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule